// File: doc/BRIEF.md
# Write-Protection Arbiter for Configuration, Fault and Memory Writes

This block sits between a serial slave's write path and the storage it updates. For each write request it decides three things: whether the write may take effect, whether the byte should go unacknowledged, and whether a nonvolatile write cycle has to start. Its inputs are the target of the write (a control register index, the fault register, or a memory byte address), the write data, the current value of control register 1, the hardware write-protect pin and a flag that reports whether the programming supply is present.

The block holds the one volatile piece of state in the protection scheme: the write-enable latch. A reset clears the latch. A write of the set code or the clear code to control register 0 updates it. All other protection inputs are decoded on the fly from control register 1 and the pin. Decisions are combinational and apply in the cycle a request is presented. The block never applies back-pressure, so `req_ready` is held high and a request counts as accepted in every cycle where `req_valid` is high. The latch changes at the clock edge that ends an accepted control-register-0 write.

Top module: `wp_write_gate`

## Requirements
- R1: After reset the enable latch is clear. An accepted write of 80h to control register 0 (`req_kind`=0, `req_idx`=0) sets it, and a write of 00h clears it. Both writes return allow=1, suppress=0, nv=0.
- R2: A write to control register 0 with any other data returns allow=0, suppress=0, nv=0 and leaves the latch unchanged.
- R3: A write to the fault register (`req_kind`=1) always returns allow=1, suppress=0, nv=0, whatever the state of the latch, pin or supply.
- R4: While the latch is clear, writes to control registers 1–3 and to memory (`req_kind`=2) return allow=0 and nv=0. They are still acknowledged unless R6 applies.
- R5: Block protect is taken from `cfg1_val[4:3]`. 00 protects nothing, 01 protects C0h–FFh, 10 protects 80h–FFh and 11 protects the whole memory.
- R6: A memory write inside the protected range returns allow=0, suppress=1, nv=0, whatever the latch holds.
- R7: When `wp_pin`=1 and `cfg1_val[7]`=1, writes to control registers 1–3 return allow=0, suppress=0, nv=0.
- R8: A write to control registers 1–3 or to memory that passes R4–R7 and has the supply present returns allow=1, suppress=0, nv=1. Writes to control register 0 or to the fault register never raise nv.
- R9: A write that passes R4–R7 while `vp_ok`=0 returns allow=0, suppress=1, nv=0.
- R10: `req_ready` is always 1. While `req_valid`=0, all three outputs are 0 and the latch holds its value.
- R11: A request with `req_kind`=3 (reserved) returns allow=0, suppress=1, nv=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Always 1; the block never stalls |
| req_kind | input | 2 | 0 control register, 1 fault register, 2 memory, 3 reserved |
| req_idx | input | 2 | Control register index |
| req_addr | input | ADDR_W | Memory byte address |
| req_data | input | DATA_W | Write data |
| cfg1_val | input | DATA_W | Current value of control register 1 |
| wp_pin | input | 1 | Hardware write-protect pin |
| vp_ok | input | 1 | Programming supply present |
| wr_allow | output | 1 | Write may take effect |
| ack_suppress | output | 1 | Do not acknowledge this byte |
| nv_start | output | 1 | Start a nonvolatile write cycle |

## Verification
The bench uses the default ADDR_W=8 and DATA_W=8. At these widths the quarter and half boundaries fall exactly at C0h and 80h, so addresses on both sides of every range edge can be applied. The bench sweeps every combination of latch state, pin, supply, protect-enable bit and block-protect code against every kind of target. It also covers legal and illegal control-register-0 data, and follows an illegal write with a probe write that shows whether the latch was disturbed.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    TK_CTRL  = 2'd0,
    TK_FAULT = 2'd1,
    TK_MEM   = 2'd2,
    TK_RSVD  = 2'd3
  } tgt_kind_e;

  typedef struct packed {
    logic allow;
    logic nak;
    logic nv;
  } verdict_t;

  localparam int BP_LO = 3;

  localparam verdict_t V_DROP_ACK = '{allow: 1'b0, nak: 1'b0, nv: 1'b0};
  localparam verdict_t V_DROP_NAK = '{allow: 1'b0, nak: 1'b1, nv: 1'b0};
  localparam verdict_t V_PASS_VOL = '{allow: 1'b1, nak: 1'b0, nv: 1'b0};
  localparam verdict_t V_PASS_NV  = '{allow: 1'b1, nak: 1'b0, nv: 1'b1};
endpackage

// File: rtl/wp_enable_latch.sv
module wp_enable_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [DATA_W-1:0] wdata,
  output logic              legal,
  output logic              wel
);
  localparam logic [DATA_W-1:0] SET_CODE = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] CLR_CODE = '0;

  assign legal = (wdata == SET_CODE) || (wdata == CLR_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             wel <= 1'b0;
    else if (upd && legal)  wel <= wdata[DATA_W-1];
  end

  p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && wdata == SET_CODE) |=> wel);
  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && wdata == CLR_CODE) |=> !wel);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd || (wdata != SET_CODE && wdata != CLR_CODE)) |=> $stable(wel));
endmodule

// File: rtl/wp_block_decode.sv
module wp_block_decode #(
  parameter int ADDR_W = 8
) (
  input  logic [1:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              prot
);
  logic in_half, in_quarter;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign in_half    = addr[ADDR_W-1];
      assign in_quarter = &addr[ADDR_W-1 -: 2];
    end else begin : g_narrow
      assign in_half    = addr[0];
      assign in_quarter = addr[0];
    end
  endgenerate

  always_comb begin
    unique case (bp)
      2'b00:   prot = 1'b0;
      2'b01:   prot = in_quarter;
      2'b10:   prot = in_half;
      default: prot = 1'b1;
    endcase
  end
endmodule

// File: rtl/wp_rule_core.sv
module wp_rule_core
  import wp_pkg::*;
(
  input  logic      valid,
  input  tgt_kind_e kind,
  input  logic [1:0] idx,
  input  logic      cr0_legal,
  input  logic      wel,
  input  logic      hw_lock,
  input  logic      mem_prot,
  input  logic      vp_ok,
  output verdict_t  vd
);
  logic cand;

  always_comb begin
    vd   = V_DROP_ACK;
    cand = 1'b0;
    if (valid) begin
      unique case (kind)
        TK_CTRL: begin
          if (idx == 2'd0) begin
            vd = cr0_legal ? V_PASS_VOL : V_DROP_ACK;
          end else begin
            cand = wel && !hw_lock;
            if (cand) vd = vp_ok ? V_PASS_NV : V_DROP_NAK;
          end
        end
        TK_FAULT: vd = V_PASS_VOL;
        TK_MEM: begin
          if (mem_prot) begin
            vd = V_DROP_NAK;
          end else begin
            cand = wel;
            if (cand) vd = vp_ok ? V_PASS_NV : V_DROP_NAK;
          end
        end
        default: vd = V_DROP_NAK;
      endcase
    end
  end
endmodule

// File: rtl/wp_write_gate.sv
module wp_write_gate
  import wp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_idx,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [DATA_W-1:0] cfg1_val,
  input  logic              wp_pin,
  input  logic              vp_ok,
  output logic              wr_allow,
  output logic              ack_suppress,
  output logic              nv_start
);
  localparam int WPEN_BIT = DATA_W - 1;

  tgt_kind_e kind;
  logic      cr0_upd, cr0_legal, wel, hw_lock, mem_prot;
  logic [1:0] bp;
  verdict_t  vd;
  logic      cfg_unused;

  assign req_ready  = 1'b1;
  assign kind       = tgt_kind_e'(req_kind);
  assign cr0_upd    = req_valid && req_ready && kind == TK_CTRL && req_idx == 2'd0;
  assign hw_lock    = wp_pin && cfg1_val[WPEN_BIT];
  assign bp         = cfg1_val[BP_LO +: 2];
  assign cfg_unused = ^cfg1_val;

  wp_enable_latch #(.DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .upd(cr0_upd), .wdata(req_data),
    .legal(cr0_legal), .wel(wel)
  );

  wp_block_decode #(.ADDR_W(ADDR_W)) u_bp (
    .bp(bp), .addr(req_addr), .prot(mem_prot)
  );

  wp_rule_core u_core (
    .valid(req_valid), .kind(kind), .idx(req_idx), .cr0_legal(cr0_legal),
    .wel(wel), .hw_lock(hw_lock), .mem_prot(mem_prot), .vp_ok(vp_ok), .vd(vd)
  );

  assign wr_allow     = vd.allow;
  assign ack_suppress = vd.nak;
  assign nv_start     = vd.nv;

  p_fault_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && kind == TK_FAULT) |-> (wr_allow && !ack_suppress && !nv_start));
  p_latch_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !wel && (kind == TK_MEM || (kind == TK_CTRL && req_idx != 2'd0)))
      |-> (!wr_allow && !nv_start));
  p_prot_nak_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && kind == TK_MEM && mem_prot) |-> (ack_suppress && !wr_allow));
  p_hw_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hw_lock && kind == TK_CTRL && req_idx != 2'd0) |-> !wr_allow);
  p_cr0_volatile_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cr0_upd |-> !nv_start);
  p_nv_vp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nv_start |-> (vp_ok && wr_allow));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!wr_allow && !ack_suppress && !nv_start));
  p_one_verdict_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_allow, ack_suppress}));
endmodule

// File: tb/sim_wp_write_gate.sv
module sim_wp_write_gate;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_kind = 2'd0;
  logic [1:0] req_idx = 2'd0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_data = '0;
  logic [DATA_W-1:0] cfg1_val = '0;
  logic wp_pin = 1'b0;
  logic vp_ok = 1'b0;
  logic wr_allow, ack_suppress, nv_start;

  int n_chk = 0;
  int n_bad = 0;
  logic exp_wel = 1'b0;

  always #2 clk = ~clk;

  wp_write_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_idx(req_idx), .req_addr(req_addr),
    .req_data(req_data), .cfg1_val(cfg1_val), .wp_pin(wp_pin), .vp_ok(vp_ok),
    .wr_allow(wr_allow), .ack_suppress(ack_suppress), .nv_start(nv_start)
  );

  task automatic check3(input string tag, input logic [2:0] exp);
    n_chk++;
    if ({wr_allow, ack_suppress, nv_start} !== exp || req_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL %s kind=%0d idx=%0d addr=%h data=%h cfg=%h wp=%b vp=%b wel=%b actual=%b%b expected=%b",
               tag, req_kind, req_idx, req_addr, req_data, cfg1_val, wp_pin, vp_ok,
               exp_wel, req_ready, {wr_allow, ack_suppress, nv_start}, {1'b1, exp});
    end
  endtask

  // Reference model: returns {allow, suppress, nv} and a requirement tag.
  task automatic model(input logic [1:0] k, input logic [1:0] ix, input logic [7:0] a,
                       input logic [7:0] d, output logic [2:0] e, output string tag);
    logic prot, cand;
    e = 3'b000;
    if (k == 2'd3) begin e = 3'b010; tag = "R11"; end
    else if (k == 2'd1) begin e = 3'b100; tag = "R3"; end
    else if (k == 2'd0 && ix == 2'd0) begin
      if (d == 8'h00 || d == 8'h80) begin e = 3'b100; tag = "R1"; end
      else begin e = 3'b000; tag = "R2"; end
    end else begin
      case (cfg1_val[4:3])
        2'd0: prot = 1'b0;
        2'd1: prot = (a >= 8'hC0);
        2'd2: prot = (a >= 8'h80);
        default: prot = 1'b1;
      endcase
      if (k == 2'd2 && prot) begin e = 3'b010; tag = "R5/R6"; end
      else begin
        cand = exp_wel && !(k == 2'd0 && wp_pin && cfg1_val[7]);
        if (!exp_wel) tag = "R4";
        else if (!cand) tag = "R7";
        else if (!vp_ok) tag = "R9";
        else tag = "R8";
        if (cand) e = vp_ok ? 3'b101 : 3'b010;
      end
    end
  endtask

  task automatic apply(input logic [1:0] k, input logic [1:0] ix, input logic [7:0] a,
                       input logic [7:0] d);
    logic [2:0] e;
    string tag;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_idx = ix; req_addr = a; req_data = d;
    model(k, ix, a, d, e, tag);
    #1 check3(tag, e);
    @(posedge clk);
    if (k == 2'd0 && ix == 2'd0 && (d == 8'h00 || d == 8'h80)) exp_wel = d[7];
    #0.5 req_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] addrs [8];
    addrs = '{8'h00, 8'h3F, 8'h40, 8'h7F, 8'h80, 8'hBF, 8'hC0, 8'hFF};

    // R1: latch clear during and after reset (probe memory write, no protection)
    vp_ok = 1'b1; cfg1_val = 8'h00;
    req_valid = 1'b1; req_kind = 2'd2; req_addr = 8'h10;
    #3 check3("R1", 3'b000);
    req_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    apply(2'd2, 2'd0, 8'h10, 8'h5A);

    // R10: idle request gives no verdict
    @(negedge clk);
    req_valid = 1'b0; req_kind = 2'd1;
    #1 check3("R10", 3'b000);

    // R2: illegal codes leave the latch alone, observed through a probe write
    apply(2'd0, 2'd0, 8'h00, 8'h80);
    apply(2'd0, 2'd0, 8'h00, 8'h55);
    apply(2'd2, 2'd0, 8'h00, 8'h11);
    apply(2'd0, 2'd0, 8'h00, 8'h00);
    apply(2'd0, 2'd0, 8'h00, 8'h81);
    apply(2'd2, 2'd0, 8'h00, 8'h11);

    // Full sweep: latch x pin x supply x protect-enable x block-protect x target
    for (int w = 0; w < 2; w++)
      for (int p = 0; p < 2; p++)
        for (int v = 0; v < 2; v++)
          for (int c = 0; c < 8; c++) begin
            wp_pin = p[0]; vp_ok = v[0];
            cfg1_val = {c[2], 2'b00, c[1:0], 3'b000};
            apply(2'd0, 2'd0, 8'h00, w[0] ? 8'h80 : 8'h00);
            apply(2'd1, 2'd0, 8'h00, 8'h0F);
            apply(2'd3, 2'd0, 8'h00, 8'h0F);
            for (int ix = 1; ix < 4; ix++) apply(2'd0, ix[1:0], 8'h00, 8'hA5);
            for (int i = 0; i < 8; i++) apply(2'd2, 2'd0, addrs[i], 8'h3C);
            apply(2'd0, 2'd0, 8'h00, 8'h7F);
            apply(2'd2, 2'd0, 8'h00, 8'h3C);
          end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule